// File: doc/BRIEF.md
# Serial Link Low-Power Mode and Wakeup Controller

This block manages the power states of the digital part of a serial data-link controller on a single-wire vehicle network. The CPU issues wait and stop requests. A configuration input decides whether a wait request gives a wait mode, where the link logic stays clocked, or a stop mode, where the link clock is shut off. The block keeps its mode in a small state machine and drives a clock enable for the rest of the link logic. It raises a wakeup interrupt request that stays set until the CPU acknowledges it.

Each low-power mode has its own wakeup sources. In wait mode, a rising edge on the network receive line (passive 0 to active 1) or a valid end-of-frame strobe from the symbol decoder wakes the link. In stop mode only line activity can wake it, because the activity detector is the only logic that keeps running. The receive line passes through a synchronizer before the edge detector.

A registered loopback switch disconnects the digital transmit and receive paths from the physical interface. It feeds the transmit data straight back to the receive side and holds the bus driver passive. This lets a node tell a fault in its own logic apart from a fault on the network.

Top module: `lpm_wake_ctrl`

## Requirements
- R1: After reset, mode_o is run (2'b00), irq_o is 0, clk_en_o is 1 and loopback is off.
- R2: In run mode, wait_req_i with wait_as_stop_i clear moves mode_o to wait (2'b01) at the next edge, and clk_en_o stays 1 in wait mode.
- R3: In run mode, stop_req_i, or wait_req_i with wait_as_stop_i set, moves mode_o to stop (2'b10) at the next edge. Stop takes priority over wait. clk_en_o is 0 for as long as the block is in stop mode.
- R4: A 0-to-1 change on phy_rx_i passes through two synchronizer flops. When phy_rx_i is high at edge k after being low at edge k-1, the edge event happens at edge k+2. In wait mode that event sets irq_o and returns mode_o to run.
- R5: In wait mode, eof_valid_i high at an edge sets irq_o and returns mode_o to run at that edge.
- R6: In stop mode, the synchronized rising edge of phy_rx_i sets irq_o and returns mode_o to run, so clk_en_o goes back to 1. eof_valid_i has no effect in stop mode.
- R7: irq_o stays 1 until irq_ack_i is high at an edge, which clears it. An acknowledge wins over a wakeup event at the same edge, and the mode still returns to run.
- R8: In run mode, line edges and eof_valid_i do not set irq_o. Wait and stop requests have no effect outside run mode.
- R9: loopback_en_i is registered. While the registered value is 1, rx_digital_o equals tx_digital_i and phy_tx_o is 0 (passive). While it is 0, rx_digital_o equals phy_rx_i and phy_tx_o equals tx_digital_i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| wait_req_i | input | 1 | CPU wait request |
| stop_req_i | input | 1 | CPU stop request |
| wait_as_stop_i | input | 1 | When 1, a wait request enters stop mode |
| eof_valid_i | input | 1 | Valid end-of-frame strobe from the symbol decoder |
| irq_ack_i | input | 1 | One-cycle acknowledge that clears irq_o |
| loopback_en_i | input | 1 | Loopback select, registered |
| tx_digital_i | input | 1 | Transmit data from the link logic |
| rx_digital_o | output | 1 | Receive data to the link logic |
| phy_rx_i | input | 1 | Receive line from the physical interface (0 passive) |
| phy_tx_o | output | 1 | Bus driver output to the physical interface (0 passive) |
| clk_en_o | output | 1 | Clock enable for the link logic |
| irq_o | output | 1 | Wakeup interrupt request |
| mode_o | output | 2 | Mode: 00 run, 01 wait, 10 stop |

## Verification
The hardest case to reach is a wakeup event that coincides with an acknowledge while the block is asleep. It needs a pending interrupt left uncleared, a new low-power entry and a line edge that was launched two cycles before the acknowledge. A directed sequence builds this on purpose, and random stimulus with sparse acknowledges and occasional line toggles produces further mixes. A cycle-level expected model in the bench tracks the synchronizer delay so that every edge wakeup is compared at the exact edge.

// File: rtl/lpm_pkg.sv
package lpm_pkg;
  typedef enum logic [1:0] {
    MODE_RUN  = 2'b00,
    MODE_WAIT = 2'b01,
    MODE_STOP = 2'b10
  } lpm_mode_e;
endpackage

// File: rtl/lpm_rx_sync.sv
module lpm_rx_sync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic line_i,
  output logic rise_o
);
  localparam int LAST = SYNC_STAGES - 1;

  // stages 0..LAST synchronize; stage SYNC_STAGES holds the previous value
  logic [SYNC_STAGES:0] pipe_q;
  logic [SYNC_STAGES:0] pipe_d;

  always_comb begin
    pipe_d[0] = line_i;
  end

  for (genvar g = 1; g <= SYNC_STAGES; g++) begin : g_stage
    always_comb pipe_d[g] = pipe_q[g-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pipe_q <= '0;
    else        pipe_q <= pipe_d;
  end

  assign rise_o = pipe_q[LAST] & ~pipe_q[SYNC_STAGES];

  // an edge event lasts one cycle only
  assert_rise_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
    rise_o |=> !rise_o);
endmodule

// File: rtl/lpm_mode_fsm.sv
module lpm_mode_fsm
  import lpm_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      wait_req_i,
  input  logic      stop_req_i,
  input  logic      wait_as_stop_i,
  input  logic      eof_valid_i,
  input  logic      line_rise_i,
  input  logic      irq_ack_i,
  output lpm_mode_e mode_o,
  output logic      irq_o
);
  lpm_mode_e mode_q, mode_d;
  logic      irq_q, irq_d;
  logic      wake;
  logic      go_stop, go_wait;

  always_comb begin
    go_stop = stop_req_i | (wait_req_i & wait_as_stop_i);
    go_wait = wait_req_i & ~wait_as_stop_i;
    unique case (mode_q)
      MODE_WAIT: wake = line_rise_i | eof_valid_i;
      MODE_STOP: wake = line_rise_i;
      default:   wake = 1'b0;
    endcase
  end

  always_comb begin
    mode_d = mode_q;
    unique case (mode_q)
      MODE_RUN: begin
        if (go_stop)      mode_d = MODE_STOP;
        else if (go_wait) mode_d = MODE_WAIT;
      end
      MODE_WAIT, MODE_STOP: begin
        if (wake) mode_d = MODE_RUN;
      end
      default: mode_d = MODE_RUN;
    endcase
  end

  always_comb begin
    irq_d = irq_q;
    if (irq_ack_i) irq_d = 1'b0;
    else if (wake) irq_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= MODE_RUN;
      irq_q  <= 1'b0;
    end else begin
      mode_q <= mode_d;
      irq_q  <= irq_d;
    end
  end

  assign mode_o = mode_q;
  assign irq_o  = irq_q;

  assert_stop_entry_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == MODE_RUN && stop_req_i) |=> mode_q == MODE_STOP);
  assert_wait_entry_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == MODE_RUN && wait_req_i && !wait_as_stop_i && !stop_req_i) |=> mode_q == MODE_WAIT);
  assert_eof_wake_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == MODE_WAIT && eof_valid_i && !irq_ack_i) |=> (irq_q && mode_q == MODE_RUN));
  assert_stop_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == MODE_STOP && !line_rise_i) |=> mode_q == MODE_STOP);
  assert_ack_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
    irq_ack_i |=> !irq_q);
  assert_run_no_irq_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == MODE_RUN && !irq_q) |=> !irq_q);
endmodule

// File: rtl/lpm_loop_switch.sv
module lpm_loop_switch (
  input  logic clk,
  input  logic rst_n,
  input  logic loop_req_i,
  input  logic tx_digital_i,
  input  logic phy_rx_i,
  output logic rx_digital_o,
  output logic phy_tx_o
);
  logic loop_q;
  logic loop_d;

  always_comb loop_d = loop_req_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) loop_q <= 1'b0;
    else        loop_q <= loop_d;
  end

  always_comb begin
    if (loop_q) begin
      rx_digital_o = tx_digital_i;
      phy_tx_o     = 1'b0;
    end else begin
      rx_digital_o = phy_rx_i;
      phy_tx_o     = tx_digital_i;
    end
  end

  assert_loop_passive_R9: assert property (@(posedge clk) disable iff (!rst_n)
    loop_req_i |=> !phy_tx_o);
endmodule

// File: rtl/lpm_wake_ctrl.sv
module lpm_wake_ctrl
  import lpm_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wait_req_i,
  input  logic       stop_req_i,
  input  logic       wait_as_stop_i,
  input  logic       eof_valid_i,
  input  logic       irq_ack_i,
  input  logic       loopback_en_i,
  input  logic       tx_digital_i,
  output logic       rx_digital_o,
  input  logic       phy_rx_i,
  output logic       phy_tx_o,
  output logic       clk_en_o,
  output logic       irq_o,
  output logic [1:0] mode_o
);
  logic      line_rise;
  lpm_mode_e mode;

  lpm_rx_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
    .clk    (clk),
    .rst_n  (rst_n),
    .line_i (phy_rx_i),
    .rise_o (line_rise)
  );

  lpm_mode_fsm u_fsm (
    .clk            (clk),
    .rst_n          (rst_n),
    .wait_req_i     (wait_req_i),
    .stop_req_i     (stop_req_i),
    .wait_as_stop_i (wait_as_stop_i),
    .eof_valid_i    (eof_valid_i),
    .line_rise_i    (line_rise),
    .irq_ack_i      (irq_ack_i),
    .mode_o         (mode),
    .irq_o          (irq_o)
  );

  lpm_loop_switch u_loop (
    .clk          (clk),
    .rst_n        (rst_n),
    .loop_req_i   (loopback_en_i),
    .tx_digital_i (tx_digital_i),
    .phy_rx_i     (phy_rx_i),
    .rx_digital_o (rx_digital_o),
    .phy_tx_o     (phy_tx_o)
  );

  assign clk_en_o = (mode != MODE_STOP);
  assign mode_o   = mode;

  assert_stop_gates_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_o == 2'b00 && stop_req_i) |=> !clk_en_o);
  assert_stop_wake_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_o == 2'b10 && line_rise && !irq_ack_i) |=> (clk_en_o && irq_o));
endmodule

// File: tb/lpm_wake_ctrl_test.sv
module lpm_wake_ctrl_test;
  logic clk = 1'b0;
  logic rst_n;
  logic wait_req, stop_req, cfg, eof, ack, lb, tx, rx_line;
  logic rx_dig, phy_tx, clk_en, irq;
  logic [1:0] mode;

  int n_checks = 0;
  int n_fail   = 0;

  // expected model state
  logic [1:0] m_mode;
  logic m_irq, m_lb, m_s1, m_s2, m_s3;

  always #4 clk = ~clk;

  lpm_wake_ctrl uut (
    .clk(clk), .rst_n(rst_n), .wait_req_i(wait_req), .stop_req_i(stop_req),
    .wait_as_stop_i(cfg), .eof_valid_i(eof), .irq_ack_i(ack),
    .loopback_en_i(lb), .tx_digital_i(tx), .rx_digital_o(rx_dig),
    .phy_rx_i(rx_line), .phy_tx_o(phy_tx), .clk_en_o(clk_en),
    .irq_o(irq), .mode_o(mode)
  );

  task automatic check(input string tag, input logic [1:0] act, input logic [1:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [1:0] next_mode(input logic [1:0] cur, input logic w,
      input logic s, input logic c, input logic wk);
    if (cur == 2'b00) begin
      if (s || (w && c)) return 2'b10;
      if (w) return 2'b01;
      return 2'b00;
    end
    return wk ? 2'b00 : cur;
  endfunction

  task automatic check_state();
    check("R2/R3 mode", mode, m_mode);
    check("R5/R7 irq", {1'b0, irq}, {1'b0, m_irq});
    check("R3 clk_en", {1'b0, clk_en}, {1'b0, m_mode != 2'b10});
  endtask

  task automatic check_loop();
    check("R9 rx_digital", {1'b0, rx_dig}, {1'b0, m_lb ? tx : rx_line});
    check("R9 phy_tx", {1'b0, phy_tx}, {1'b0, m_lb ? 1'b0 : tx});
  endtask

  // inputs already driven; advance one edge, update model, check at negedge
  task automatic step();
    logic rise, wk;
    #1 check_loop();
    @(posedge clk);
    rise = m_s2 & ~m_s3;
    wk = (m_mode == 2'b01 && (rise || eof)) || (m_mode == 2'b10 && rise);
    m_mode = next_mode(m_mode, wait_req, stop_req, cfg, wk);
    m_irq  = ack ? 1'b0 : (wk ? 1'b1 : m_irq);
    m_s3 = m_s2; m_s2 = m_s1; m_s1 = rx_line; m_lb = lb;
    @(negedge clk);
    check_state();
  endtask

  task automatic idle_in();
    wait_req = 0; stop_req = 0; eof = 0; ack = 0;
  endtask

  initial begin
    #(8 * 150000);
    n_fail++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    rst_n = 0; idle_in(); cfg = 0; lb = 0; tx = 0; rx_line = 0;
    m_mode = 2'b00; m_irq = 0; m_lb = 0; m_s1 = 0; m_s2 = 0; m_s3 = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    #1;
    // R1 reset state
    check("R1 mode", mode, 2'b00);
    check("R1 irq", {1'b0, irq}, 2'b00);
    check("R1 clk_en", {1'b0, clk_en}, 2'b01);
    tx = 1; #1 check("R1 loopback off", {1'b0, phy_tx}, 2'b01);
    tx = 0;

    // R8: events in run do not set irq
    eof = 1; step(); idle_in();
    rx_line = 1; repeat (4) step();
    check("R8 no irq in run", {1'b0, irq}, 2'b00);
    rx_line = 0; repeat (3) step();

    // R2 + R5: wait then eof wake
    wait_req = 1; step(); idle_in();
    check("R2 wait mode", mode, 2'b01);
    check("R2 clk_en in wait", {1'b0, clk_en}, 2'b01);
    stop_req = 1; step(); idle_in();
    check("R8 stop ignored in wait", mode, 2'b01);
    eof = 1; step(); idle_in();
    check("R5 eof wake", {irq, mode == 2'b00}, 2'b11);
    step(); check("R7 irq held", {1'b0, irq}, 2'b01);
    ack = 1; step(); idle_in();
    check("R7 ack clears", {1'b0, irq}, 2'b00);

    // R3 + R6: stop via wait with cfg set, eof ignored, edge wakes
    cfg = 1; wait_req = 1; step(); idle_in(); cfg = 0;
    check("R3 stop via cfg", {clk_en, mode == 2'b10}, 2'b01);
    eof = 1; step(); idle_in();
    check("R6 eof ignored in stop", {irq, mode == 2'b10}, 2'b01);
    rx_line = 1; step(); step();
    check("R4 no wake before sync", mode, 2'b10);
    step();
    check("R6 edge wakes stop", {irq, clk_en}, 2'b11);

    // R4 + R7: wait wake by edge coinciding with ack
    rx_line = 0; repeat (3) step();
    wait_req = 1; step(); idle_in();
    rx_line = 1; step(); step();
    ack = 1; step(); idle_in();
    check("R7 ack beats wake", {irq, mode == 2'b00}, 2'b01);
    rx_line = 0; repeat (3) step();

    // R9 loopback
    lb = 1; step(); lb = 1;
    tx = 1; #1 check("R9 loop tx to rx", {rx_dig, phy_tx}, 2'b10);
    tx = 0; rx_line = 1; #1 check("R9 loop ignores line", {1'b0, rx_dig}, 2'b00);
    rx_line = 0; lb = 0; step();

    // random phase
    for (int i = 0; i < 4000; i++) begin
      wait_req = ($urandom % 10) == 0;
      stop_req = ($urandom % 16) == 0;
      cfg      = ($urandom % 3) == 0;
      eof      = ($urandom % 9) == 0;
      ack      = ($urandom % 7) == 0;
      lb       = ($urandom % 8) == 0;
      tx       = $urandom % 2;
      if (($urandom % 5) == 0) rx_line = ~rx_line;
      step();
    end

    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule